// File: doc/BRIEF.md
# Photon-Counting Measurement Sequencer

This block runs a repeated time-correlated photon-counting measurement. A start request in idle begins a series. Each measurement raises the inhibit line and pulses the detector reset and the converter reset together. It then fires a one-cycle laser trigger and opens an event-acceptance window for a programmed number of clock cycles. When the window closes, the analog read switch is turned on. The sequencer waits out a settling interval, latches the converter's fine phase bits and reads the analog coarse value through a serial ADC. Finally it presents the phase bits and the digitised coarse value together as one raw result word.

The reset pulse width, window length, settling time and number of measurements are configuration inputs, counted in clock cycles. They are sampled when a series starts. The settling interval is never shorter than a parameterised floor, which is set to the 800 ns equivalent at the system clock rate. Histogram accumulation happens downstream.

Top module: `tcspc_seq`

## Requirements
- R1: After reset, or whenever the sequencer is idle, inhibit, det_rst, tdc_rst, laser_trig, expose, read_sw, res_valid and done are low and adc_cs_n is high.
- R2: A start pulse in idle raises inhibit on the next clock. Inhibit stays high until the cycle after done.
- R3: At the beginning of every measurement, det_rst and tdc_rst are high together for max(cfg_rst_len,1) cycles, while expose and read_sw are low.
- R4: laser_trig is high for exactly one cycle, and that cycle is the first cycle of each exposure window.
- R5: expose follows the reset pulse and is high for max(cfg_exp_len,1) consecutive cycles. expose and read_sw are never high together.
- R6: read_sw rises when the window closes. adc_cs_n stays high for exactly max(cfg_settle_len, MIN_SETTLE_CYC) cycles after that, and no conversion ever starts with fewer than MIN_SETTLE_CYC settle cycles.
- R7: A conversion holds adc_cs_n low only while read_sw is high, for 16 SCLK periods. Each period is SCLK_HALF cycles low followed by SCLK_HALF cycles high, and adc_sclk idles low. adc_cs_n is low for 32*SCLK_HALF cycles in total. adc_sdo is sampled on each rising SCLK edge. The last 12 bits sampled form the coarse value, MSB first, after four leading bits.
- R8: phase_in is captured in the clock where the settle interval ends, which is the same edge at which adc_cs_n falls. Later changes on phase_in do not alter the result.
- R9: res_valid is a single-cycle pulse per measurement. res_data is {phase bits, 12-bit coarse value}, with the phase bits in the upper PH_W bits.
- R10: A series runs max(cfg_meas_cnt,1) measurements back to back. done is high in the same cycle as the final res_valid.
- R11: A start pulse while a series is running is ignored. Configuration inputs changed during a series have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request for a measurement series |
| cfg_rst_len | input | TW | Reset pulse width in cycles (0 acts as 1) |
| cfg_exp_len | input | TW | Exposure window length in cycles (0 acts as 1) |
| cfg_settle_len | input | TW | Settle time in cycles, raised to MIN_SETTLE_CYC if smaller |
| cfg_meas_cnt | input | CW | Measurements per series (0 acts as 1) |
| phase_in | input | PH_W | Fine phase bits latched by the converter |
| adc_sdo | input | 1 | Serial data from the ADC |
| inhibit | output | 1 | High while a series is in progress |
| det_rst | output | 1 | Detector reset pulse |
| tdc_rst | output | 1 | Converter reset pulse |
| laser_trig | output | 1 | One-cycle laser trigger |
| expose | output | 1 | Event-acceptance window |
| read_sw | output | 1 | Analog read switch enable |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_sclk | output | 1 | ADC serial clock |
| res_valid | output | 1 | Result word valid pulse |
| res_data | output | PH_W+ADC_W | {phase bits, coarse value} |
| done | output | 1 | Series complete, coincides with last res_valid |

## Verification
The bench builds the block with TW=8, CW=4 and MIN_SETTLE_CYC=20. These values let settle requests both below and at the floor reach the clamp boundary, and they keep each measurement near a hundred cycles. SCLK_HALF=2 is used, so the exact chip-select length of 64 cycles can be checked. Zero-valued lengths and a zero measurement count exercise the treat-as-one rule. A three-measurement series with the configuration scrambled mid-run shows that values are latched at start. A phase change after capture, a start pulse during a series and a reset in mid-series cover the remaining corner cases.

// File: rtl/tcspc_pkg.sv
package tcspc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_EXPO,
        S_SETTLE,
        S_CONV,
        S_OUT
    } seq_state_e;
endpackage

// File: rtl/tcspc_timer.sv
module tcspc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/tcspc_adc_rd.sv
module tcspc_adc_rd #(
    parameter int DW    = 12,
    parameter int FRAME = 16,
    parameter int HALF  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          sdo,
    output logic          cs_n,
    output logic          sclk,
    output logic          fin,
    output logic [DW-1:0] data
);
    localparam int BW  = $clog2(FRAME + 1);
    localparam int DVW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [DVW-1:0]   div;
        logic [BW-1:0]    bits;
        logic [FRAME-1:0] sh;
        logic             fin;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.fin = 1'b0;
        if (!rd_q.active) begin
            if (go) begin
                rd_d.active = 1'b1;
                rd_d.sclk   = 1'b0;
                rd_d.div    = DVW'(HALF - 1);
                rd_d.bits   = '0;
            end
        end else if (rd_q.div != '0) begin
            rd_d.div = rd_q.div - 1'b1;
        end else begin
            rd_d.div = DVW'(HALF - 1);
            if (!rd_q.sclk) begin
                rd_d.sclk = 1'b1;
                rd_d.sh   = {rd_q.sh[FRAME-2:0], sdo};
                rd_d.bits = rd_q.bits + 1'b1;
            end else begin
                rd_d.sclk = 1'b0;
                if (rd_q.bits == BW'(FRAME)) begin
                    rd_d.active = 1'b0;
                    rd_d.fin    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign cs_n = ~rd_q.active;
    assign sclk = rd_q.sclk;
    assign fin  = rd_q.fin;
    assign data = rd_q.sh[DW-1:0];
endmodule

// File: rtl/tcspc_seq.sv
module tcspc_seq
    import tcspc_pkg::*;
#(
    parameter int TW             = 16,
    parameter int CW             = 16,
    parameter int PH_W           = 4,
    parameter int ADC_W          = 12,
    parameter int ADC_FRAME      = 16,
    parameter int SCLK_HALF      = 2,
    parameter int MIN_SETTLE_CYC = 80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [TW-1:0]         cfg_rst_len,
    input  logic [TW-1:0]         cfg_exp_len,
    input  logic [TW-1:0]         cfg_settle_len,
    input  logic [CW-1:0]         cfg_meas_cnt,
    input  logic [PH_W-1:0]       phase_in,
    input  logic                  adc_sdo,
    output logic                  inhibit,
    output logic                  det_rst,
    output logic                  tdc_rst,
    output logic                  laser_trig,
    output logic                  expose,
    output logic                  read_sw,
    output logic                  adc_cs_n,
    output logic                  adc_sclk,
    output logic                  res_valid,
    output logic [PH_W+ADC_W-1:0] res_data,
    output logic                  done
);
    localparam int RW = PH_W + ADC_W;
    localparam logic [TW-1:0] MIN_M1 = TW'(MIN_SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [CW-1:0]   meas;
        logic [CW-1:0]   target;
        logic [TW-1:0]   rst_m1;
        logic [TW-1:0]   exp_m1;
        logic [TW-1:0]   set_m1;
        logic [PH_W-1:0] phase;
        logic [RW-1:0]   res;
        logic            fire;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             tmr_load, tmr_last;
    logic [TW-1:0]    tmr_val;
    logic             adc_go, adc_fin;
    logic [ADC_W-1:0] adc_data;

    // effective configuration, sampled only when a series starts
    logic [TW-1:0] rst_m1_c, exp_m1_c, set_m1_c;
    logic [CW-1:0] target_c;

    always_comb begin
        rst_m1_c = (cfg_rst_len == '0) ? '0 : cfg_rst_len - 1'b1;
        exp_m1_c = (cfg_exp_len == '0) ? '0 : cfg_exp_len - 1'b1;
        set_m1_c = (cfg_settle_len < TW'(MIN_SETTLE_CYC)) ? MIN_M1
                                                           : cfg_settle_len - 1'b1;
        target_c = (cfg_meas_cnt == '0) ? CW'(1) : cfg_meas_cnt;
    end

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = seq_q.rst_m1;
        adc_go   = 1'b0;
        case (seq_q.state)
            S_IDLE: begin
                if (start) begin
                    seq_d.state  = S_RST;
                    seq_d.meas   = '0;
                    seq_d.target = target_c;
                    seq_d.rst_m1 = rst_m1_c;
                    seq_d.exp_m1 = exp_m1_c;
                    seq_d.set_m1 = set_m1_c;
                    tmr_load     = 1'b1;
                    tmr_val      = rst_m1_c;
                end
            end
            S_RST: begin
                if (tmr_last) begin
                    seq_d.state = S_EXPO;
                    seq_d.fire  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = seq_q.exp_m1;
                end
            end
            S_EXPO: begin
                seq_d.fire = 1'b0;
                if (tmr_last) begin
                    seq_d.state = S_SETTLE;
                    tmr_load    = 1'b1;
                    tmr_val     = seq_q.set_m1;
                end
            end
            S_SETTLE: begin
                if (tmr_last) begin
                    seq_d.state = S_CONV;
                    seq_d.phase = phase_in;
                    adc_go      = 1'b1;
                end
            end
            S_CONV: begin
                if (adc_fin) begin
                    seq_d.state = S_OUT;
                    seq_d.res   = {seq_q.phase, adc_data};
                    seq_d.meas  = seq_q.meas + 1'b1;
                end
            end
            S_OUT: begin
                if (seq_q.meas == seq_q.target) begin
                    seq_d.state = S_IDLE;
                end else begin
                    seq_d.state = S_RST;
                    tmr_load    = 1'b1;
                    tmr_val     = seq_q.rst_m1;
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    tcspc_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    tcspc_adc_rd #(.DW(ADC_W), .FRAME(ADC_FRAME), .HALF(SCLK_HALF)) u_adc (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (adc_go),
        .sdo   (adc_sdo),
        .cs_n  (adc_cs_n),
        .sclk  (adc_sclk),
        .fin   (adc_fin),
        .data  (adc_data)
    );

    assign inhibit    = (seq_q.state != S_IDLE);
    assign det_rst    = (seq_q.state == S_RST);
    assign tdc_rst    = (seq_q.state == S_RST);
    assign expose     = (seq_q.state == S_EXPO);
    assign laser_trig = seq_q.fire;
    assign read_sw    = (seq_q.state == S_SETTLE) || (seq_q.state == S_CONV);
    assign res_valid  = (seq_q.state == S_OUT);
    assign res_data   = seq_q.res;
    assign done       = (seq_q.state == S_OUT) && (seq_q.meas == seq_q.target);
endmodule

// File: rtl/tcspc_seq_chk.sv
module tcspc_seq_chk #(
    parameter int TW             = 16,
    parameter int MIN_SETTLE_CYC = 80
) (
    input logic clk,
    input logic rst_n,
    input logic inhibit,
    input logic det_rst,
    input logic tdc_rst,
    input logic laser_trig,
    input logic expose,
    input logic read_sw,
    input logic adc_cs_n,
    input logic res_valid,
    input logic done
);
    logic [TW:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            settle_q <= '0;
        else if (!read_sw)
            settle_q <= '0;
        else if (adc_cs_n && settle_q != '1)
            settle_q <= settle_q + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |-> (!det_rst && !tdc_rst && !expose && !read_sw && adc_cs_n && !res_valid));

    // R3
    rst_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_rst |-> (inhibit && !expose && !read_sw));

    // R4
    laser_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        laser_trig |-> (expose && !$past(expose)));

    // R4
    laser_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        laser_trig |=> !laser_trig);

    // R5
    window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(expose && read_sw));

    // R6
    settle_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (settle_q >= (TW+1)'(MIN_SETTLE_CYC)));

    // R7
    cs_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> read_sw);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R10
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !inhibit);
endmodule

bind tcspc_seq tcspc_seq_chk #(.TW(TW), .MIN_SETTLE_CYC(MIN_SETTLE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inhibit    (inhibit),
    .det_rst    (det_rst),
    .tdc_rst    (tdc_rst),
    .laser_trig (laser_trig),
    .expose     (expose),
    .read_sw    (read_sw),
    .adc_cs_n   (adc_cs_n),
    .res_valid  (res_valid),
    .done       (done)
);

// File: tb/sim_tcspc_seq.sv
module sim_tcspc_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TW    = 8;
    localparam int CW    = 4;
    localparam int PH_W  = 4;
    localparam int ADC_W = 12;
    localparam int HALF  = 2;
    localparam int MINS  = 20;
    localparam int WDOG  = 150000;
    localparam int NVEC  = 4;

    // {rst_len, exp_len, settle_len, meas_cnt, phase, adc_value}
    localparam logic [43:0] VEC [0:NVEC-1] = '{
        {8'd3, 8'd10, 8'd30, 4'd2, 4'h5, 12'hA5C},
        {8'd0, 8'd1,  8'd5,  4'd1, 4'hF, 12'hFFF},
        {8'd1, 8'd0,  8'd20, 4'd0, 4'h0, 12'h001},
        {8'd6, 8'd40, 8'd21, 4'd3, 4'h9, 12'h800}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TW-1:0] cfg_rst_len = '0, cfg_exp_len = '0, cfg_settle_len = '0;
    logic [CW-1:0] cfg_meas_cnt = '0;
    logic [PH_W-1:0] phase_in = '0;
    logic adc_sdo;
    logic inhibit, det_rst, tdc_rst, laser_trig, expose, read_sw;
    logic adc_cs_n, adc_sclk, res_valid, done;
    logic [PH_W+ADC_W-1:0] res_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] adc_frame = '0;
    int rise_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcspc_seq #(.TW(TW), .CW(CW), .PH_W(PH_W), .ADC_W(ADC_W), .ADC_FRAME(16),
                .SCLK_HALF(HALF), .MIN_SETTLE_CYC(MINS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rst_len(cfg_rst_len), .cfg_exp_len(cfg_exp_len),
        .cfg_settle_len(cfg_settle_len), .cfg_meas_cnt(cfg_meas_cnt),
        .phase_in(phase_in), .adc_sdo(adc_sdo),
        .inhibit(inhibit), .det_rst(det_rst), .tdc_rst(tdc_rst),
        .laser_trig(laser_trig), .expose(expose), .read_sw(read_sw),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .res_valid(res_valid),
        .res_data(res_data), .done(done)
    );

    // ADC model: new bit after every rising SCLK edge, four zeros then data MSB first
    always @(posedge adc_sclk or posedge adc_cs_n) begin
        if (adc_cs_n) rise_cnt <= 0;
        else          rise_cnt <= rise_cnt + 1;
    end
    assign adc_sdo = (!adc_cs_n && rise_cnt < 16) ? adc_frame[15 - rise_cnt] : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic idle_check(input string req);
        chk(!inhibit && !det_rst && !tdc_rst && !laser_trig && !expose && !read_sw
            && adc_cs_n && !res_valid && !done, req,
            {inhibit, det_rst, tdc_rst, laser_trig, expose, read_sw, adc_cs_n, res_valid, done},
            9'b000000100);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_vec(input logic [43:0] v);
        int r, e, s, n, ph, av;
        int er, ee, es, en;
        int rst_run, exp_run, set_run, cs_run, res_cnt, meas_seen;
        bit prev_rst, prev_exp, prev_cs, conv_seen, fin, bad_pair, bad_inh, bad_laser;
        r = int'(v[43:36]); e = int'(v[35:28]); s = int'(v[27:20]);
        n = int'(v[19:16]); ph = int'(v[15:12]); av = int'(v[11:0]);
        er = (r == 0) ? 1 : r;
        ee = (e == 0) ? 1 : e;
        es = (s < MINS) ? MINS : s;
        en = (n == 0) ? 1 : n;
        cfg_rst_len = TW'(r); cfg_exp_len = TW'(e); cfg_settle_len = TW'(s);
        cfg_meas_cnt = CW'(n); phase_in = PH_W'(ph); adc_frame = {4'b0000, 12'(av)};
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(inhibit == 1'b1, "R2 inhibit after start", int'(inhibit), 1);
        rst_run = 1; exp_run = 0; set_run = 0; cs_run = 0; res_cnt = 0; meas_seen = 0;
        prev_rst = det_rst; prev_exp = 1'b0; prev_cs = 1'b1;
        conv_seen = 1'b0; fin = 1'b0; bad_pair = 1'b0; bad_inh = 1'b0; bad_laser = 1'b0;
        for (int c = 0; c < 5000 && !fin; c++) begin
            @(negedge clk);
            start = (c == 4);
            if (det_rst != tdc_rst) bad_pair = 1'b1;
            if (!inhibit) bad_inh = 1'b1;
            if (det_rst) begin
                rst_run++;
            end else if (prev_rst) begin
                chk(rst_run == er, "R3 reset pulse width", rst_run, er);
                rst_run = 0;
                cfg_rst_len = 8'd200; cfg_exp_len = 8'd3;
                cfg_settle_len = 8'd100; cfg_meas_cnt = 4'd15;
            end
            if (expose) begin
                exp_run++;
                if (laser_trig != (exp_run == 1)) bad_laser = 1'b1;
            end else begin
                if (laser_trig) bad_laser = 1'b1;
                if (prev_exp) begin
                    chk(exp_run == ee, "R5 exposure length", exp_run, ee);
                    exp_run = 0;
                end
            end
            if (read_sw && adc_cs_n && !conv_seen) set_run++;
            if (!adc_cs_n) cs_run++;
            if (!adc_cs_n && prev_cs) begin
                chk(set_run == es, "R6 settle interval", set_run, es);
                set_run = 0;
                conv_seen = 1'b1;
                phase_in = ~PH_W'(ph);
            end
            if (adc_cs_n && !prev_cs) begin
                chk(cs_run == 32*HALF, "R7 chip select length", cs_run, 32*HALF);
                cs_run = 0;
            end
            if (res_valid) begin
                chk(res_data == {PH_W'(ph), 12'(av)}, "R9 R8 R7 result word",
                    int'(res_data), int'({PH_W'(ph), 12'(av)}));
                res_cnt++;
                conv_seen = 1'b0;
                phase_in = PH_W'(ph);
            end
            if (done) begin
                chk(res_valid == 1'b1, "R10 done with last result", int'(res_valid), 1);
                chk(res_cnt == en, "R10 R11 measurement count", res_cnt, en);
                fin = 1'b1;
            end
            prev_rst = det_rst; prev_exp = expose; prev_cs = adc_cs_n;
        end
        start = 1'b0;
        chk(fin, "R10 series completed", int'(fin), 1);
        chk(!bad_pair, "R3 resets pulse together", int'(bad_pair), 0);
        chk(!bad_inh, "R2 inhibit held during series", int'(bad_inh), 0);
        chk(!bad_laser, "R4 laser on first window cycle", int'(bad_laser), 0);
        @(negedge clk);
        idle_check("R2 R1 idle after done");
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (inhibit || res_valid) meas_seen++;
        end
        chk(meas_seen == 0, "R11 no activity after series", meas_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        idle_check("R1 idle after reset release");

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i]);
        end

        // reset in the middle of a series
        cfg_rst_len = 8'd6; cfg_exp_len = 8'd40; cfg_settle_len = 8'd21; cfg_meas_cnt = 4'd3;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        chk(expose == 1'b1, "R5 window open before reset", int'(expose), 1);
        rst_n = 1'b0;
        #1;
        idle_check("R1 asynchronous reset mid-series");
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);
        idle_check("R1 stays idle without start");

        // a short series after the interrupted one
        run_vec({8'd2, 8'd4, 8'd19, 4'd1, 4'h3, 12'h5A5});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule